// File: doc/BRIEF.md
# 5x5 Fixed-Point Convolution Engine

This block is a sequential engine for a two-dimensional convolution with a 5x5 kernel over a signed fixed-point image in a local memory. A controller loads the image, the 25 coefficients and the current contents of the output memory, then selects the geometry, a normalization shift and the element width. After a start pulse the engine produces only the valid region of the result. Each output word is written back to the location the engine read it from.

For each output position the engine reads the word already stored there and sign-extends it. It shifts that word left by the normalization amount to form the initial value of a 32-bit accumulator, which serves as a bias or a partial sum carried over from an earlier run. It then adds the 25 products, one multiply-accumulate per cycle. The final value is shifted right arithmetically by the same amount and truncated to the element width before it is written back. Repeated runs over the same output buffer therefore chain partial sums, for example across input channels.

All three memories are plain synchronous RAMs with a read latency of one cycle. The memories belong to the surrounding system. The engine only drives addresses, reads the returned data and issues write strobes for the output memory.

Top module: `conv5x5_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done` and `out_we` are low.
- R2: A run accepted on width W and height H, both at least 5, writes exactly (W-4)*(H-4) outputs, ordered row by row. Output (l, c) is written to address l*W+c, using the input row stride. The first write occurs 27 cycles after the accepting clock edge, and each further write follows 27 cycles later.
- R3: The accumulator for an output starts as the sign-extended word already stored at that output address, shifted left by the normalization amount.
- R4: The 25 products coefficient[kr*5+kc] * input[(l+kr)*W + c+kc], for kr and kc from 0 to 4, are all added to the accumulator.
- R5: The written value is the 32-bit accumulator, with wrap-around on overflow, shifted right arithmetically by the normalization amount and truncated to the element width.
- R6: With `byte_mode` = 1, only bits [7:0] of every word read are used, sign-extended. The written word holds the 8-bit result sign-extended to 16 bits. With `byte_mode` = 0, all 16 bits are used as signed values.
- R7: `done` is high for exactly one cycle, the cycle after the last write. `busy` is high from the cycle after the accepting edge through the `done` cycle.
- R8: If W < 5 or H < 5, the run performs no write and raises `done` in the first cycle after the accepting edge.
- R9: A `start` seen while `busy` is high, including the `done` cycle, is ignored. The run in progress keeps its schedule, and no new run begins.
- R10: Geometry, shift and mode are captured at the accepting edge. Changing those inputs during a run has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| byte_mode | input | 1 | 1: 8-bit elements, 0: 16-bit elements |
| img_w | input | DIMW | Image width W in elements |
| img_h | input | DIMW | Image height H in rows |
| norm | input | NW | Normalization shift amount |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| in_addr | output | AW | Input image read address |
| in_rdata | input | DW | Input image read data (one cycle after address) |
| flt_addr | output | 5 | Coefficient read address |
| flt_rdata | input | DW | Coefficient read data |
| out_addr | output | AW | Output read and write address |
| out_rdata | input | DW | Output memory read data |
| out_we | output | 1 | Output write strobe |
| out_wdata | output | DW | Output write data |

## Verification
Two events can collide in the same cycle: the end-of-run `done` pulse and a fresh `start`. A start raised during the `done` cycle must be dropped, not begin a second run. The bench raises `start` exactly in the `done` cycle of one run, and in the middle of another run. Its reference timeline then expects `busy` to fall and no write to appear on the following clocks. The bench also checks that the interrupted run's writes keep their 27-cycle spacing and their values.

// File: rtl/conv5x5_engine.sv
module conv5x5_engine #(
  parameter int DW   = 16,
  parameter int AW   = 10,
  parameter int DIMW = 6,
  parameter int NW   = 5,
  parameter int ACCW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            byte_mode,
  input  logic [DIMW-1:0] img_w,
  input  logic [DIMW-1:0] img_h,
  input  logic [NW-1:0]   norm,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_rdata,
  output logic [4:0]      flt_addr,
  input  logic [DW-1:0]   flt_rdata,
  output logic [AW-1:0]   out_addr,
  input  logic [DW-1:0]   out_rdata,
  output logic            out_we,
  output logic [DW-1:0]   out_wdata
);
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_MAC, S_WR, S_DONE} st_t;

  st_t                    st;
  logic [DIMW-1:0]        w_q, h_q, row, col;
  logic [NW-1:0]          norm_q;
  logic                   byte_q;
  logic [2:0]             kr, kc;
  logic [4:0]             rcv;
  logic signed [ACCW-1:0] acc, pre, base, shr;
  logic signed [2*DW-1:0] prod;

  function automatic logic signed [DW-1:0] elem(input logic [DW-1:0] v, input logic b);
    return b ? {{BW{v[BW-1]}}, v[BW-1:0]} : v;
  endfunction

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_DONE);
  assign out_we = (st == S_WR);

  assign in_addr  = (AW'(row) + AW'(kr)) * AW'(w_q) + AW'(col) + AW'(kc);
  assign flt_addr = 5'(kr) * 5'd5 + 5'(kc);
  assign out_addr = AW'(row) * AW'(w_q) + AW'(col);

  assign prod = elem(in_rdata, byte_q) * elem(flt_rdata, byte_q);
  assign pre  = ACCW'(elem(out_rdata, byte_q)) <<< norm_q;
  assign base = (rcv == 5'd0) ? pre : acc;
  assign shr  = acc >>> norm_q;
  assign out_wdata = byte_q ? {{BW{shr[BW-1]}}, shr[BW-1:0]} : shr[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      w_q <= '0; h_q <= '0; norm_q <= '0; byte_q <= 1'b0;
      row <= '0; col <= '0; kr <= '0; kc <= '0; rcv <= '0;
      acc <= '0;
    end else begin
      if (st == S_RD || st == S_MAC) begin
        if (kc == 3'd4) begin
          kc <= '0;
          kr <= kr + 3'd1;
        end else begin
          kc <= kc + 3'd1;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          w_q <= img_w; h_q <= img_h; norm_q <= norm; byte_q <= byte_mode;
          row <= '0; col <= '0; kr <= '0; kc <= '0;
          st <= (img_w < DIMW'(5) || img_h < DIMW'(5)) ? S_DONE : S_RD;
        end
        S_RD: begin
          rcv <= '0;
          st  <= S_MAC;
        end
        S_MAC: begin
          acc <= base + ACCW'(prod);
          rcv <= rcv + 5'd1;
          if (rcv == 5'd24) st <= S_WR;
        end
        S_WR: begin
          kr <= '0; kc <= '0;
          if (col == w_q - DIMW'(5)) begin
            col <= '0;
            if (row == h_q - DIMW'(5)) st <= S_DONE;
            else begin
              row <= row + DIMW'(1);
              st  <= S_RD;
            end
          end else begin
            col <= col + DIMW'(1);
            st  <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv5x5_engine_chk.sv
module conv5x5_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          out_we,
  input logic [DW-1:0] out_wdata,
  input logic          byte_q
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_we && !done));

  p_write_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> !out_we);

  p_byte_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && byte_q) |-> (out_wdata[DW-1:DW/2] == {(DW/2){out_wdata[DW/2-1]}}));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_we) || $past(start)));

  p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind conv5x5_engine conv5x5_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_we(out_we), .out_wdata(out_wdata), .byte_q(byte_q)
);

// File: tb/test_conv5x5_engine.sv
module test_conv5x5_engine;
  localparam int DW = 16, AW = 10, DIMW = 6, NW = 5;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_mode = 1'b0;
  logic [DIMW-1:0] img_w = '0, img_h = '0;
  logic [NW-1:0]   norm = '0;
  logic busy, done, out_we;
  logic [AW-1:0] in_addr, out_addr;
  logic [4:0]    flt_addr;
  logic [DW-1:0] in_rdata = '0, flt_rdata = '0, out_rdata = '0, out_wdata;

  logic [DW-1:0] in_mem  [MEMN];
  logic [DW-1:0] flt_mem [32];
  logic [DW-1:0] out_mem [MEMN];

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  conv5x5_engine #(.DW(DW), .AW(AW), .DIMW(DIMW), .NW(NW)) i_conv5x5_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
    .img_w(img_w), .img_h(img_h), .norm(norm), .busy(busy), .done(done),
    .in_addr(in_addr), .in_rdata(in_rdata), .flt_addr(flt_addr), .flt_rdata(flt_rdata),
    .out_addr(out_addr), .out_rdata(out_rdata), .out_we(out_we), .out_wdata(out_wdata)
  );

  always @(posedge clk) begin
    in_rdata  <= in_mem[in_addr];
    flt_rdata <= flt_mem[flt_addr];
    out_rdata <= out_mem[out_addr];
    if (out_we) out_mem[out_addr] <= out_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int elem(input logic [15:0] v, input bit b);
    if (b) return int'($signed(v[7:0]));
    return int'($signed(v));
  endfunction

  task automatic fill();
    for (int i = 0; i < MEMN; i++) begin
      in_mem[i]  = 16'($urandom);
      out_mem[i] = 16'($urandom);
    end
    for (int i = 0; i < 32; i++) flt_mem[i] = 16'($urandom);
  endtask

  task automatic run_conv(input int w, input int h, input int nrm, input bit bm,
                          input string tag, input int poke, input bit disturb);
    int n, last, idx, acc, r;
    int q_addr[$];
    logic [15:0] q_data[$];
    bit exp_we;
    n = (w >= 5 && h >= 5) ? (w - 4) * (h - 4) : 0;
    for (int l = 0; l < h - 4; l++)
      for (int c = 0; c < w - 4; c++) begin
        acc = elem(out_mem[l*w+c], bm) <<< nrm;
        for (int kl = 0; kl < 5; kl++)
          for (int kc = 0; kc < 5; kc++)
            acc += elem(flt_mem[kl*5+kc], bm) * elem(in_mem[(l+kl)*w+c+kc], bm);
        r = acc >>> nrm;
        q_addr.push_back(l*w + c);
        q_data.push_back(bm ? {{8{r[7]}}, r[7:0]} : r[15:0]);
      end
    @(negedge clk);
    img_w = DIMW'(w); img_h = DIMW'(h); norm = NW'(nrm); byte_mode = bm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    last = 27*n + 1;
    for (int cyc = 1; cyc <= last + 2; cyc++) begin
      if (cyc > 1) @(negedge clk);
      exp_we = (n > 0) && (cyc <= 27*n) && (cyc % 27 == 0);
      chk(out_we == exp_we, {tag, " R2 write strobe"}, int'(out_we), int'(exp_we));
      chk(done == (cyc == last), {tag, " R7/R8 done"}, int'(done), int'(cyc == last));
      chk(busy == (cyc <= last), {tag, " R7/R9 busy"}, int'(busy), int'(cyc <= last));
      if (exp_we) begin
        idx = cyc/27 - 1;
        chk(int'(out_addr) == q_addr[idx], {tag, " R2 address"}, int'(out_addr), q_addr[idx]);
        chk(out_wdata == q_data[idx], {tag, " R3/R4/R5/R6 value"}, int'(out_wdata), int'(q_data[idx]));
      end
      start = (cyc == poke);
      if (disturb && cyc == 5) begin
        img_w = DIMW'(w + 3); img_h = DIMW'(4); norm = NW'(nrm + 1); byte_mode = ~bm;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog R7: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle state after reset
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(!out_we, "R1 write after reset", int'(out_we), 0);
    // R2 R3 R4 R5: 16-bit run on random data with preloaded outputs
    run_conv(8, 7, 2, 1'b0, "wide", 0, 1'b0);
    // R3 chaining on the same buffer; R9 start mid-run ignored
    run_conv(8, 7, 2, 1'b0, "chain", 40, 1'b0);
    // R6 byte mode with garbage upper bits; R10 inputs changed mid-run
    run_conv(6, 6, 0, 1'b1, "byte", 0, 1'b1);
    // R5 maximum shift, wrap of the accumulator
    run_conv(5, 5, 31, 1'b0, "shift31", 0, 1'b0);
    run_conv(7, 5, 7, 1'b1, "byte7", 0, 1'b0);
    // R8 degenerate geometries
    run_conv(4, 9, 3, 1'b0, "narrow", 0, 1'b0);
    run_conv(9, 3, 3, 1'b0, "short", 0, 1'b0);
    // R9 start exactly in the done cycle: 2 outputs, done at cycle 55
    run_conv(6, 5, 1, 1'b0, "collide", 55, 1'b0);
    run_conv(4, 4, 0, 1'b0, "collide0", 1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule